// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address when paging is on. It walks a page directory and then a page table, both held in memory. It reads and writes memory one 32-bit word at a time through a request/ready port. A request is taken only while the walker is idle. The block reports completion with a one-cycle `done` strobe. That strobe carries either the physical address or a page-fault indication with the fault vector.

The linear address splits into three fields: a 10-bit directory index in bits 31..22, a 10-bit table index in bits 21..12 and a 12-bit byte offset. Every entry is one 4-byte word. As it walks, the block sets the accessed flag in both entries it uses. On a write it also sets the dirty flag in the leaf entry. An entry is written back only when one of those flags actually changes.

A one-entry translation cache holds the last virtual page number and its frame. A hit skips the walk entirely. A write that hits a page whose leaf entry is not yet marked dirty still takes the walk, so that the dirty flag gets set. Writing the directory base flushes the cache.

Top module: `xl_pagewalk`

## Requirements
- R1: With `pg_en` low, an accepted request completes with `done` high one cycle after acceptance, `phys_addr` equal to `req_lin`, `fault` low and no memory access.
- R2: The directory entry is read from `{dir_base[31:12], req_lin[31:22], 2'b00}`. The low 12 bits of `dir_base` have no effect.
- R3: The table entry is read from `{pde[31:12], req_lin[21:12], 2'b00}`. The physical address is `{pte[31:12], req_lin[11:0]}`.
- R4: If bit 0 (present) of either entry is 0, the walk stops with no further memory access. `done` and `fault` are then high together and `fault_vec` equals 14.
- R5: On a fault, `fault_addr` takes the full faulting linear address. It holds that value through later successful translations until the next fault.
- R6: Bit 5 (accessed) is set in the directory entry and in the table entry. Each entry is written back, with bits 0 and 5 set, only if bit 5 was clear when read.
- R7: On a write request, bit 6 (dirty) of the table entry is set and written back if it was clear. A read request never sets bit 6.
- R8: A request whose page matches the last successful walk completes one cycle after acceptance with no memory access. The exception is a write whose cached leaf entry does not have bit 6 set; that write performs a full walk.
- R9: A pulse on `dir_base_wr` empties the translation cache, so the next request to any page performs a full walk.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when idle |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read access |
| pg_en | input | 1 | Paging enable; 0 bypasses translation |
| dir_base | input | 32 | Physical base of the page directory |
| dir_base_wr | input | 1 | Pulse marking a write of the directory base |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 1 | Page fault, valid with `done` |
| fault_vec | output | 8 | Fault vector (14) while `fault` is high, else 0 |
| fault_addr | output | 32 | Linear address of the most recent fault |
| phys_addr | output | 32 | Translated address, valid with `done` |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | 32 | Word address of the entry |
| mem_wdata | output | 32 | Entry value written back |
| mem_rdata | input | 32 | Entry value read |
| mem_ready | input | 1 | Access completes on this cycle |

## Verification
The bench goes after these corner cases:

- **Directory base with junk in its low 12 bits.** A walker that added those bits in would read the wrong directory word.
- **Entries that already carry the accessed flag.** A walker that always wrote back would show extra memory writes.
- **Dirty flag on reads versus writes.** A walker that marked pages dirty on reads, or skipped the flag on writes, would leave wrong entry values in memory.
- **Write hitting a page first cached by a read.** A cache that ignored dirty state would finish at once and never set the leaf's dirty flag.
- **Faults at each level.** Missing present bits at the directory level and at the table level are each checked for extra accesses and for the exact fault address.
- **Fault register after a successful translation.** A register that lost or overwrote its value would fail this check.
- **Flush on base write.** A cache that survived the flush would skip the expected walk.

// File: rtl/xl_pkg.sv
package xl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_RD_DIR = 3'd1,
      ST_WR_DIR = 3'd2,
      ST_RD_TBL = 3'd3,
      ST_WR_TBL = 3'd4
   } walk_st_e;

   localparam int DEF_PRESENT_BIT  = 0;
   localparam int DEF_ACCESSED_BIT = 5;
   localparam int DEF_DIRTY_BIT    = 6;
   localparam int DEF_FAULT_VEC    = 14;

endpackage

// File: rtl/xl_xlate_cache.sv
module xl_xlate_cache #(
   parameter int VPN_W    = 20,
   parameter int FRAME_W  = 20,
   parameter bit CACHE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [VPN_W-1:0]   look_vpn,
   input  logic               look_wr,
   output logic               hit,
   output logic [FRAME_W-1:0] hit_pfn,
   input  logic               fill,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [FRAME_W-1:0] fill_pfn,
   input  logic               fill_dirty
);

   generate
      if (CACHE_EN) begin : g_cache
         logic               vld_q;
         logic               dty_q;
         logic [VPN_W-1:0]   vpn_q;
         logic [FRAME_W-1:0] pfn_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dty_q <= 1'b0;
               vpn_q <= '0;
               pfn_q <= '0;
            end else if (flush) begin
               vld_q <= 1'b0;
            end else if (fill) begin
               vld_q <= 1'b1;
               dty_q <= fill_dirty;
               vpn_q <= fill_vpn;
               pfn_q <= fill_pfn;
            end
         end

         assign hit     = vld_q && (vpn_q == look_vpn) && (!look_wr || dty_q);
         assign hit_pfn = pfn_q;

         AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> !hit) else $error("flush left a live entry"); // R9
      end else begin : g_nocache
         logic unused_cache_in;
         assign unused_cache_in = ^{flush, look_vpn, look_wr, fill, fill_vpn, fill_pfn, fill_dirty};
         assign hit     = 1'b0;
         assign hit_pfn = '0;
      end
   endgenerate

endmodule

// File: rtl/xl_fault_capture.sv
module xl_fault_capture #(
   parameter int LA_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt,
   input  logic [LA_W-1:0] lin,
   output logic [LA_W-1:0] fault_addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fault_addr <= '0;
      else if (evt) fault_addr <= lin;
   end

   AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> fault_addr == $past(lin)) else $error("fault address not captured"); // R5
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !evt |=> $stable(fault_addr)) else $error("fault address moved"); // R5

endmodule

// File: rtl/xl_walk_ctrl.sv
module xl_walk_ctrl
   import xl_pkg::*;
#(
   parameter int LA_W         = 32,
   parameter int DIR_BITS     = 10,
   parameter int TBL_BITS     = 10,
   parameter int OFF_BITS     = 12,
   parameter int ENTRY_BYTES  = 4,
   parameter int PRESENT_BIT  = DEF_PRESENT_BIT,
   parameter int ACCESSED_BIT = DEF_ACCESSED_BIT,
   parameter int DIRTY_BIT    = DEF_DIRTY_BIT,
   parameter int VEC_W        = 8,
   parameter int FAULT_VEC    = DEF_FAULT_VEC,
   localparam int FRAME_W     = LA_W - OFF_BITS,
   localparam int VPN_W       = DIR_BITS + TBL_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [LA_W-1:0]    req_lin,
   input  logic               req_write,
   input  logic               pg_en,
   input  logic [LA_W-1:0]    dir_base,
   input  logic               c_hit,
   input  logic [FRAME_W-1:0] c_pfn,
   output logic               c_fill,
   output logic [VPN_W-1:0]   c_fill_vpn,
   output logic [FRAME_W-1:0] c_fill_pfn,
   output logic               c_fill_dirty,
   output logic               fault_evt,
   output logic [LA_W-1:0]    fault_lin,
   output logic               done_o,
   output logic               fault_o,
   output logic [VEC_W-1:0]   vec_o,
   output logic [LA_W-1:0]    phys_o,
   output logic               mem_req,
   output logic               mem_we,
   output logic [LA_W-1:0]    mem_addr,
   output logic [LA_W-1:0]    mem_wdata,
   input  logic [LA_W-1:0]    mem_rdata,
   input  logic               mem_ready
);

   localparam int ENT_LSB = $clog2(ENTRY_BYTES);
   localparam logic [LA_W-1:0] A_MASK = LA_W'(1) << ACCESSED_BIT;
   localparam logic [LA_W-1:0] D_MASK = LA_W'(1) << DIRTY_BIT;

   initial begin
      assert (DIR_BITS + TBL_BITS + OFF_BITS == LA_W) else $error("address split does not cover LA_W");
      assert (DIR_BITS + ENT_LSB == OFF_BITS) else $error("directory must fill one frame");
      assert (TBL_BITS + ENT_LSB == OFF_BITS) else $error("table must fill one frame");
      assert (FAULT_VEC < (1 << VEC_W)) else $error("fault vector does not fit");
      assert (PRESENT_BIT < OFF_BITS && ACCESSED_BIT < OFF_BITS && DIRTY_BIT < OFF_BITS)
         else $error("flag bits must lie below the frame field");
   end

   walk_st_e           st;
   logic [LA_W-1:0]    lin_q;
   logic               wr_q;
   logic [FRAME_W-1:0] base_q;
   logic [FRAME_W-1:0] tbl_q;
   logic [LA_W-1:0]    ent_q;
   logic [LA_W-1:0]    leaf_new;
   logic [LA_W-1:0]    leaf_word;
   logic               rd_phase;
   logic               entry_absent;
   logic               leaf_ok_nowb;

   logic unused_base;
   assign unused_base = ^dir_base[OFF_BITS-1:0];

   assign rd_phase     = (st == ST_RD_DIR) || (st == ST_RD_TBL);
   assign entry_absent = !mem_rdata[PRESENT_BIT];
   assign leaf_new     = mem_rdata | A_MASK | (wr_q ? D_MASK : '0);
   assign leaf_ok_nowb = (st == ST_RD_TBL) && mem_ready && !entry_absent && (leaf_new == mem_rdata);
   assign leaf_word    = (st == ST_WR_TBL) ? ent_q : leaf_new;

   // memory side is a pure function of state, so it holds while waiting
   always_comb begin
      mem_req   = (st != ST_IDLE);
      mem_we    = (st == ST_WR_DIR) || (st == ST_WR_TBL);
      mem_wdata = ent_q;
      if ((st == ST_RD_DIR) || (st == ST_WR_DIR))
         mem_addr = {base_q, lin_q[LA_W-1 -: DIR_BITS], {ENT_LSB{1'b0}}};
      else
         mem_addr = {tbl_q, lin_q[OFF_BITS+TBL_BITS-1 -: TBL_BITS], {ENT_LSB{1'b0}}};
   end

   assign fault_evt    = rd_phase && mem_ready && entry_absent;
   assign fault_lin    = lin_q;
   assign c_fill       = leaf_ok_nowb || ((st == ST_WR_TBL) && mem_ready);
   assign c_fill_vpn   = lin_q[LA_W-1 -: VPN_W];
   assign c_fill_pfn   = leaf_word[LA_W-1 -: FRAME_W];
   assign c_fill_dirty = leaf_word[DIRTY_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         lin_q   <= '0;
         wr_q    <= 1'b0;
         base_q  <= '0;
         tbl_q   <= '0;
         ent_q   <= '0;
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         vec_o   <= '0;
         phys_o  <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         vec_o   <= '0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  lin_q  <= req_lin;
                  wr_q   <= req_write;
                  base_q <= dir_base[LA_W-1 -: FRAME_W];
                  if (!pg_en) begin
                     done_o <= 1'b1;
                     phys_o <= req_lin;
                  end else if (c_hit) begin
                     done_o <= 1'b1;
                     phys_o <= {c_pfn, req_lin[OFF_BITS-1:0]};
                  end else begin
                     st <= ST_RD_DIR;
                  end
               end
            end
            ST_RD_DIR: begin
               if (mem_ready) begin
                  if (entry_absent) begin
                     done_o  <= 1'b1;
                     fault_o <= 1'b1;
                     vec_o   <= VEC_W'(FAULT_VEC);
                     phys_o  <= '0;
                     st      <= ST_IDLE;
                  end else begin
                     tbl_q <= mem_rdata[LA_W-1 -: FRAME_W];
                     ent_q <= mem_rdata | A_MASK;
                     st    <= mem_rdata[ACCESSED_BIT] ? ST_RD_TBL : ST_WR_DIR;
                  end
               end
            end
            ST_WR_DIR: begin
               if (mem_ready) st <= ST_RD_TBL;
            end
            ST_RD_TBL: begin
               if (mem_ready) begin
                  if (entry_absent) begin
                     done_o  <= 1'b1;
                     fault_o <= 1'b1;
                     vec_o   <= VEC_W'(FAULT_VEC);
                     phys_o  <= '0;
                     st      <= ST_IDLE;
                  end else begin
                     ent_q <= leaf_new;
                     if (leaf_new == mem_rdata) begin
                        done_o <= 1'b1;
                        phys_o <= {leaf_new[LA_W-1 -: FRAME_W], lin_q[OFF_BITS-1:0]};
                        st     <= ST_IDLE;
                     end else begin
                        st <= ST_WR_TBL;
                     end
                  end
               end
            end
            ST_WR_TBL: begin
               if (mem_ready) begin
                  done_o <= 1'b1;
                  phys_o <= {ent_q[LA_W-1 -: FRAME_W], lin_q[OFF_BITS-1:0]};
                  st     <= ST_IDLE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_valid && !pg_en) |=> done_o && !fault_o && phys_o == $past(req_lin))
      else $error("bypass result wrong"); // R1
   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))
      else $error("memory request changed while waiting"); // R10
   AST_WB_MARKS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[ACCESSED_BIT] && mem_wdata[PRESENT_BIT])
      else $error("write-back without accessed flag"); // R6
   AST_DIRTY_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WR_TBL && wr_q) |-> mem_wdata[DIRTY_BIT])
      else $error("write walk did not mark leaf dirty"); // R7
   AST_FAULT_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> done_o && vec_o == VEC_W'(FAULT_VEC))
      else $error("fault without done or wrong vector"); // R4
   AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && req_valid && pg_en && c_hit) |=> done_o && !mem_req)
      else $error("cache hit touched memory"); // R8

endmodule

// File: rtl/xl_pagewalk.sv
module xl_pagewalk
   import xl_pkg::*;
#(
   parameter int LA_W         = 32,
   parameter int DIR_BITS     = 10,
   parameter int TBL_BITS     = 10,
   parameter int OFF_BITS     = 12,
   parameter int ENTRY_BYTES  = 4,
   parameter int PRESENT_BIT  = DEF_PRESENT_BIT,
   parameter int ACCESSED_BIT = DEF_ACCESSED_BIT,
   parameter int DIRTY_BIT    = DEF_DIRTY_BIT,
   parameter int VEC_W        = 8,
   parameter int FAULT_VEC    = DEF_FAULT_VEC,
   parameter bit CACHE_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [LA_W-1:0]  req_lin,
   input  logic             req_write,
   input  logic             pg_en,
   input  logic [LA_W-1:0]  dir_base,
   input  logic             dir_base_wr,
   output logic             done,
   output logic             fault,
   output logic [VEC_W-1:0] fault_vec,
   output logic [LA_W-1:0]  fault_addr,
   output logic [LA_W-1:0]  phys_addr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [LA_W-1:0]  mem_addr,
   output logic [LA_W-1:0]  mem_wdata,
   input  logic [LA_W-1:0]  mem_rdata,
   input  logic             mem_ready
);

   localparam int FRAME_W = LA_W - OFF_BITS;
   localparam int VPN_W   = DIR_BITS + TBL_BITS;

   logic               c_hit;
   logic [FRAME_W-1:0] c_pfn;
   logic               c_fill;
   logic [VPN_W-1:0]   c_fill_vpn;
   logic [FRAME_W-1:0] c_fill_pfn;
   logic               c_fill_dirty;
   logic               f_evt;
   logic [LA_W-1:0]    f_lin;

   xl_xlate_cache #(
      .VPN_W   (VPN_W),
      .FRAME_W (FRAME_W),
      .CACHE_EN(CACHE_EN)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (dir_base_wr),
      .look_vpn  (req_lin[LA_W-1 -: VPN_W]),
      .look_wr   (req_write),
      .hit       (c_hit),
      .hit_pfn   (c_pfn),
      .fill      (c_fill),
      .fill_vpn  (c_fill_vpn),
      .fill_pfn  (c_fill_pfn),
      .fill_dirty(c_fill_dirty)
   );

   xl_walk_ctrl #(
      .LA_W        (LA_W),
      .DIR_BITS    (DIR_BITS),
      .TBL_BITS    (TBL_BITS),
      .OFF_BITS    (OFF_BITS),
      .ENTRY_BYTES (ENTRY_BYTES),
      .PRESENT_BIT (PRESENT_BIT),
      .ACCESSED_BIT(ACCESSED_BIT),
      .DIRTY_BIT   (DIRTY_BIT),
      .VEC_W       (VEC_W),
      .FAULT_VEC   (FAULT_VEC)
   ) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_lin     (req_lin),
      .req_write   (req_write),
      .pg_en       (pg_en),
      .dir_base    (dir_base),
      .c_hit       (c_hit),
      .c_pfn       (c_pfn),
      .c_fill      (c_fill),
      .c_fill_vpn  (c_fill_vpn),
      .c_fill_pfn  (c_fill_pfn),
      .c_fill_dirty(c_fill_dirty),
      .fault_evt   (f_evt),
      .fault_lin   (f_lin),
      .done_o      (done),
      .fault_o     (fault),
      .vec_o       (fault_vec),
      .phys_o      (phys_addr),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_rdata   (mem_rdata),
      .mem_ready   (mem_ready)
   );

   xl_fault_capture #(
      .LA_W(LA_W)
   ) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (f_evt),
      .lin       (f_lin),
      .fault_addr(fault_addr)
   );

endmodule

// File: tb/xl_pagewalk_bench.sv
`timescale 1ns/1ps
module xl_pagewalk_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_lin = '0;
   logic        req_write = 1'b0;
   logic        pg_en = 1'b0;
   logic [31:0] dir_base = '0;
   logic        dir_base_wr = 1'b0;
   logic        done, fault;
   logic [7:0]  fault_vec;
   logic [31:0] fault_addr, phys_addr;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        mem_ready = 1'b0;

   xl_pagewalk u_xl_pagewalk (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
      .req_write(req_write), .pg_en(pg_en), .dir_base(dir_base),
      .dir_base_wr(dir_base_wr), .done(done), .fault(fault),
      .fault_vec(fault_vec), .fault_addr(fault_addr), .phys_addr(phys_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   always #4 clk = ~clk;

   int errors = 0;
   int checks = 0;

   // ---------------- memory model ----------------
   logic [31:0] mem [logic [31:0]];
   int          lat = 1;
   int          wait_cnt = 0;
   int          n_rd = 0;
   int          n_wr = 0;
   logic [31:0] rd_log [4];
   logic [31:0] acc_addr;
   logic [31:0] acc_data;
   logic        acc_we;

   function automatic logic [31:0] peek(input logic [31:0] a);
      return mem.exists(a) ? mem[a] : 32'h0;
   endfunction

   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready = 1'b0;
         if (acc_we) begin
            mem[acc_addr] = acc_data;
            n_wr++;
         end else begin
            if (n_rd < 4) rd_log[n_rd] = acc_addr;
            n_rd++;
         end
      end else if (mem_req) begin
         if (wait_cnt >= lat) begin
            acc_addr  = mem_addr;
            acc_we    = mem_we;
            acc_data  = mem_wdata;
            mem_rdata = peek(mem_addr);
            mem_ready = 1'b1;
            wait_cnt  = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=0x%08h expected=0x%08h", rq, what, act, exp);
      end
   endtask

   logic        r_fault;
   logic [31:0] r_pa;
   logic [7:0]  r_vec;
   int          r_cyc;

   task automatic xlate(input logic [31:0] lin, input bit wr);
      n_rd = 0; n_wr = 0;
      @(negedge clk);
      req_valid = 1'b1; req_lin = lin; req_write = wr;
      r_cyc = 0;
      do begin
         @(negedge clk);
         req_valid = 1'b0;
         r_cyc++;
      end while (!done && r_cyc < 400);
      r_fault = fault; r_pa = phys_addr; r_vec = fault_vec;
      if (!done) chk(1'b0, "R10", "request never completed", 32'(r_cyc), 32'd0);
      @(negedge clk);
      chk(!done, "R8", "done longer than one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic flush_cache();
      @(negedge clk); dir_base_wr = 1'b1;
      @(negedge clk); dir_base_wr = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(!done && !fault && !mem_req, "R4", "reset outputs",
          {29'd0, done, fault, mem_req}, 32'd0);
      chk(fault_addr == 32'h0, "R5", "reset fault_addr", fault_addr, 32'h0);
   endtask

   task automatic t_bypass();
      pg_en = 1'b0;
      xlate(32'hDEAD_BEEF, 1'b0);
      chk(r_pa == 32'hDEAD_BEEF && !r_fault, "R1", "bypass read pa", r_pa, 32'hDEAD_BEEF);
      chk(r_cyc == 1 && n_rd == 0 && n_wr == 0, "R1", "bypass latency/accesses",
          32'(r_cyc * 100 + n_rd + n_wr), 32'd100);
      xlate(32'h0040_3123, 1'b1);
      chk(r_pa == 32'h0040_3123 && !r_fault && n_wr == 0, "R1", "bypass write pa",
          r_pa, 32'h0040_3123);
   endtask

   task automatic t_first_read_walk();
      pg_en = 1'b1;
      lat   = 2;
      xlate(32'h0040_3123, 1'b0);
      chk(r_pa == 32'h0055_5123 && !r_fault, "R3", "walk pa", r_pa, 32'h0055_5123);
      chk(rd_log[0] == 32'h0010_0004, "R2", "directory entry address", rd_log[0], 32'h0010_0004);
      chk(rd_log[1] == 32'h0020_000C, "R3", "table entry address", rd_log[1], 32'h0020_000C);
      chk(n_rd == 2 && n_wr == 2, "R6", "read walk access count",
          32'(n_rd * 16 + n_wr), 32'h22);
      chk(peek(32'h0010_0004) == 32'h0020_0021, "R6", "directory entry accessed",
          peek(32'h0010_0004), 32'h0020_0021);
      chk(peek(32'h0020_000C) == 32'h0055_5021, "R7", "read leaves leaf clean",
          peek(32'h0020_000C), 32'h0055_5021);
   endtask

   task automatic t_hit_read();
      xlate(32'h0040_3FFC, 1'b0);
      chk(r_pa == 32'h0055_5FFC && r_cyc == 1, "R8", "hit pa/latency", r_pa, 32'h0055_5FFC);
      chk(n_rd == 0 && n_wr == 0, "R8", "hit makes no access", 32'(n_rd + n_wr), 32'd0);
   endtask

   task automatic t_write_after_read();
      lat = 0;
      xlate(32'h0040_3010, 1'b1);
      chk(r_pa == 32'h0055_5010, "R8", "write miss on clean page pa", r_pa, 32'h0055_5010);
      chk(n_rd == 2 && n_wr == 1, "R6", "only leaf written back",
          32'(n_rd * 16 + n_wr), 32'h21);
      chk(peek(32'h0020_000C) == 32'h0055_5061, "R7", "leaf dirty after write",
          peek(32'h0020_000C), 32'h0055_5061);
      xlate(32'h0040_3020, 1'b1);
      chk(r_cyc == 1 && n_rd == 0 && n_wr == 0 && r_pa == 32'h0055_5020, "R8",
          "write hit on dirty page", r_pa, 32'h0055_5020);
   endtask

   task automatic t_flush();
      flush_cache();
      lat = 3;
      xlate(32'h0040_3004, 1'b0);
      chk(n_rd == 2 && n_wr == 0, "R9", "walk after flush, no write-back",
          32'(n_rd * 16 + n_wr), 32'h20);
      chk(r_pa == 32'h0055_5004, "R9", "pa after flush", r_pa, 32'h0055_5004);
   endtask

   task automatic t_dir_fault();
      xlate(32'h0080_0000, 1'b0);
      chk(r_fault && r_vec == 8'd14, "R4", "directory fault vector", {24'd0, r_vec}, 32'd14);
      chk(n_rd == 1 && n_wr == 0, "R4", "directory fault stops walk",
          32'(n_rd * 16 + n_wr), 32'h10);
      chk(fault_addr == 32'h0080_0000, "R5", "directory fault address", fault_addr, 32'h0080_0000);
   endtask

   task automatic t_tbl_fault();
      xlate(32'h00C0_5ABC, 1'b1);
      chk(r_fault && r_vec == 8'd14, "R4", "table fault vector", {24'd0, r_vec}, 32'd14);
      chk(n_rd == 2 && n_wr == 0, "R4", "table fault, no write-back",
          32'(n_rd * 16 + n_wr), 32'h20);
      chk(fault_addr == 32'h00C0_5ABC, "R5", "table fault address", fault_addr, 32'h00C0_5ABC);
      chk(peek(32'h0030_0014) == 32'h0077_7000, "R7", "absent leaf untouched",
          peek(32'h0030_0014), 32'h0077_7000);
   endtask

   task automatic t_write_fresh();
      lat = 1;
      xlate(32'h0100_7008, 1'b1);
      chk(r_pa == 32'h0088_8008 && !r_fault, "R3", "fresh write pa", r_pa, 32'h0088_8008);
      chk(n_rd == 2 && n_wr == 2, "R6", "fresh write accesses",
          32'(n_rd * 16 + n_wr), 32'h22);
      chk(peek(32'h0040_001C) == 32'h0088_8061, "R7", "fresh leaf dirty+accessed",
          peek(32'h0040_001C), 32'h0088_8061);
      chk(peek(32'h0010_0010) == 32'h0040_0021, "R6", "fresh directory entry",
          peek(32'h0010_0010), 32'h0040_0021);
      chk(fault_addr == 32'h00C0_5ABC, "R5", "fault address held", fault_addr, 32'h00C0_5ABC);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      dir_base = 32'h0010_0ABC;            // junk low bits must be ignored (R2)
      mem[32'h0010_0004] = 32'h0020_0001;  // dir 1 -> table at 0x200000
      mem[32'h0020_000C] = 32'h0055_5001;  // tbl 3 -> frame 0x555
      mem[32'h0010_000C] = 32'h0030_0021;  // dir 3 -> table at 0x300000
      mem[32'h0030_0014] = 32'h0077_7000;  // tbl 5 absent
      mem[32'h0010_0010] = 32'h0040_0001;  // dir 4 -> table at 0x400000
      mem[32'h0040_001C] = 32'h0088_8001;  // tbl 7 -> frame 0x888
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_bypass();
      t_first_read_walk();
      t_hit_read();
      t_write_after_read();
      t_flush();
      t_dir_fault();
      t_tbl_fault();
      t_write_fresh();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule